// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block sits beside a small 8-bit processor core with a 16-bit program counter and runs the hardware part of taking and leaving an interrupt. It latches requests from a set of maskable sources: source 0 is the external line and source 1 is the timer. It waits for the core to signal the end of an instruction. It then checks the per-source and global enables, picks one source by fixed priority, and acknowledges it.

On entry the block saves the program counter and the status byte on a byte-wide stack in memory. It then reads the handler address from that source's slot in a vector table and hands the core a new PC. While this runs, the core is told to stall.

A return request issued inside a handler pops the saved values back in reverse order. The block gives the core the resumed PC and the restored status byte together, and turns the global enable back on. All stack and table traffic goes through one memory port whose read data is valid in the same cycle as the address.

Top module: `irq_vec_seq`

## Requirements
- R1: A request pulse on `irq_req` is latched as pending in the next cycle. A pending request is taken only at a clock edge where `insn_done` is high and no sequence is running. The acknowledge for that source appears in the cycle after that edge. Without `insn_done` a pending request waits indefinitely.
- R2: A pending source is taken only when both its `src_en` bit and the global enable `gie` are 1. A source that is pending but disabled keeps its pending flag, and it is taken at a later boundary once it is enabled.
- R3: When several enabled sources are pending at the same boundary, the lowest index wins. Source 0 (external) therefore beats source 1 (timer). At most one `irq_ack` bit is high in any cycle.
- R4: The push phase starts with the stack pointer at `SP_INIT`. In the cycle `irq_ack` is high and the two cycles after it, the block makes three writes. The stack pointer is incremented before each write, and each write goes to address `STACK_BASE + SP`. The bytes are written in this order: PC bits 7:0, then PC bits 15:8, then the status byte.
- R5: After the pushes come two reads of the vector slot. The slot address is `VEC_BASE + index*VEC_STRIDE`, which gives 0003h for source 0 and 000Bh for source 1. The byte at the slot address is the handler's high byte, and the byte at slot+1 is its low byte. In the next cycle `pc_load` pulses for one cycle with `pc_new` equal to {high, low}.
- R6: A return request accepted while `isr_active` is 1 reads back three bytes. The first read is at the current stack pointer and gives the status byte. The next two reads are at successively lower addresses and give PC high, then PC low. In the next cycle `pc_load` and `status_load` pulse together with the saved PC and status. After this the stack pointer is back at its value before entry.
- R7: `gie` reads 0 from the cycle of `irq_ack` onward, so a second request cannot nest. It reads 1 again from the cycle that `status_load` pulses at the end of a return.
- R8: `irq_ack` is a single-cycle pulse, and it clears the pending flag of the source it names. A later boundary with no new request for that source does not take it again.
- R9: `busy` is high from the `irq_ack` cycle through the push, vector and pop phases. It is low in the cycle that `pc_load` pulses. A return request while `isr_active` is 0 is ignored: it causes no memory access and no `busy`.
- R10: A cycle with `gie_wr` high loads `gie_wr_val` into the global enable. This write is overridden when an entry happens at the same edge. After reset the global enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Request pulses, one per source |
| src_en | input | NUM_SRC | Per-source enable |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wr_val | input | 1 | Value written to the global enable |
| insn_done | input | 1 | End-of-instruction strobe from the core |
| cur_pc | input | PC_W | PC to resume at after the handler |
| cur_status | input | DW | Status byte of the core |
| reti_req | input | 1 | Return-from-handler request |
| mem_addr | output | PC_W | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the same cycle |
| pc_load | output | 1 | One-cycle pulse: load `pc_new` |
| pc_new | output | PC_W | Handler or resume address |
| status_load | output | 1 | One-cycle pulse: load `status_new` |
| status_new | output | DW | Restored status byte |
| irq_ack | output | NUM_SRC | One-cycle acknowledge per source |
| busy | output | 1 | Stall request to the core |
| gie | output | 1 | Global interrupt enable |
| isr_active | output | 1 | A handler is running |

## Verification
The bench builds the block with two sources and the default 16-bit PC, 8-bit data and 8-bit stack pointer. It moves `SP_INIT` to 5Fh, so the stack writes land at 0060h to 0062h and cannot overlap the vector slots at 0003h and 000Bh. With that layout, one small memory model can hold the stack and both table entries. This makes it possible to check a mixed-up push or pop order byte for byte. It also exposes a high/low swap in the handler address and an off-by-one in the slot stride.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_PUSH_PCL,
      SQ_PUSH_PCH,
      SQ_PUSH_ST,
      SQ_VEC_HI,
      SQ_VEC_LO,
      SQ_POP_ST,
      SQ_POP_PCH,
      SQ_POP_PCL
   } seq_state_e;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);

   for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pend_o[g] <= 1'b0;
         else if (clr_i[g])   pend_o[g] <= 1'b0;
         else if (set_i[g])   pend_o[g] <= 1'b1;
      end
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N = 2
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);

   for (genvar g = 0; g < N; g++) begin : g_pick
      if (g == 0) begin : g_top
         assign grant_o[g] = req_i[g];
      end else begin : g_rest
         assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
      end
   end

endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
   import irq_seq_pkg::*;
#(
   parameter int unsigned          NUM_SRC    = 2,
   parameter int unsigned          PC_W       = 16,
   parameter int unsigned          DW         = 8,
   parameter int unsigned          SP_W       = 8,
   parameter logic [PC_W-1:0]      VEC_BASE   = 'h0003,
   parameter logic [PC_W-1:0]      VEC_STRIDE = 'h0008,
   parameter logic [PC_W-1:0]      STACK_BASE = 'h0000,
   parameter logic [SP_W-1:0]      SP_INIT    = 'h07
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               gie_wr,
   input  logic               gie_wr_val,
   input  logic               insn_done,
   input  logic [PC_W-1:0]    cur_pc,
   input  logic [DW-1:0]      cur_status,
   input  logic               reti_req,
   output logic [PC_W-1:0]    mem_addr,
   output logic               mem_we,
   output logic               mem_re,
   output logic [DW-1:0]      mem_wdata,
   input  logic [DW-1:0]      mem_rdata,
   output logic               pc_load,
   output logic [PC_W-1:0]    pc_new,
   output logic               status_load,
   output logic [DW-1:0]      status_new,
   output logic [NUM_SRC-1:0] irq_ack,
   output logic               busy,
   output logic               gie,
   output logic               isr_active
);

   localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 1) begin : g_chk_src
      $error("irq_vec_seq: NUM_SRC must be at least 1");
   end
   if (PC_W != 2 * DW) begin : g_chk_pc
      $error("irq_vec_seq: PC_W must be two data bytes");
   end
   if (SP_W > PC_W) begin : g_chk_sp
      $error("irq_vec_seq: SP_W must not exceed PC_W");
   end

   seq_state_e          state_q;
   logic [SP_W-1:0]     sp_q;
   logic [PC_W-1:0]     pc_sv_q;
   logic [DW-1:0]       st_sv_q;
   logic [DW-1:0]       st_pop_q;
   logic [DW-1:0]       hi_q;
   logic [SEL_W-1:0]    sel_q;
   logic                gie_q;
   logic                isr_q;
   logic [NUM_SRC-1:0]  ack_q;
   logic                pc_load_q;
   logic [PC_W-1:0]     pc_new_q;
   logic                st_load_q;
   logic [DW-1:0]       st_new_q;

   logic [NUM_SRC-1:0]  pend;
   logic [NUM_SRC-1:0]  eligible;
   logic [NUM_SRC-1:0]  grant;
   logic [SEL_W-1:0]    grant_idx;
   logic                idle;
   logic                ret_go;
   logic                take;
   logic [SP_W-1:0]     sp_inc;
   logic [SP_W-1:0]     sp_dec;
   logic [PC_W-1:0]     vec_addr;

   assign idle     = (state_q == SQ_IDLE);
   assign eligible = pend & src_en;
   assign ret_go   = idle & reti_req & isr_q;
   assign take     = idle & insn_done & gie_q & (|eligible) & ~ret_go;
   assign sp_inc   = sp_q + 1'b1;
   assign sp_dec   = sp_q - 1'b1;
   assign vec_addr = VEC_BASE + (PC_W'(sel_q) * VEC_STRIDE);

   irq_pend_bank #(.N(NUM_SRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (irq_req),
      .clr_i  (grant & {NUM_SRC{take}}),
      .pend_o (pend)
   );

   irq_prio_pick #(.N(NUM_SRC)) u_pick (
      .req_i   (eligible),
      .grant_o (grant)
   );

   always_comb begin
      grant_idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (grant[i]) grant_idx = SEL_W'(i);
      end
   end

   always_comb begin
      mem_addr  = '0;
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_wdata = '0;
      unique case (state_q)
         SQ_PUSH_PCL: begin
            mem_we    = 1'b1;
            mem_addr  = STACK_BASE + PC_W'(sp_inc);
            mem_wdata = pc_sv_q[DW-1:0];
         end
         SQ_PUSH_PCH: begin
            mem_we    = 1'b1;
            mem_addr  = STACK_BASE + PC_W'(sp_inc);
            mem_wdata = pc_sv_q[PC_W-1:DW];
         end
         SQ_PUSH_ST: begin
            mem_we    = 1'b1;
            mem_addr  = STACK_BASE + PC_W'(sp_inc);
            mem_wdata = st_sv_q;
         end
         SQ_VEC_HI: begin
            mem_re   = 1'b1;
            mem_addr = vec_addr;
         end
         SQ_VEC_LO: begin
            mem_re   = 1'b1;
            mem_addr = vec_addr + PC_W'(1);
         end
         SQ_POP_ST, SQ_POP_PCH, SQ_POP_PCL: begin
            mem_re   = 1'b1;
            mem_addr = STACK_BASE + PC_W'(sp_q);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         sp_q      <= SP_INIT;
         pc_sv_q   <= '0;
         st_sv_q   <= '0;
         st_pop_q  <= '0;
         hi_q      <= '0;
         sel_q     <= '0;
         gie_q     <= 1'b0;
         isr_q     <= 1'b0;
         ack_q     <= '0;
         pc_load_q <= 1'b0;
         pc_new_q  <= '0;
         st_load_q <= 1'b0;
         st_new_q  <= '0;
      end else begin
         ack_q     <= '0;
         pc_load_q <= 1'b0;
         st_load_q <= 1'b0;
         if (gie_wr) gie_q <= gie_wr_val;
         unique case (state_q)
            SQ_IDLE: begin
               if (ret_go) begin
                  state_q <= SQ_POP_ST;
               end else if (take) begin
                  ack_q   <= grant;
                  sel_q   <= grant_idx;
                  pc_sv_q <= cur_pc;
                  st_sv_q <= cur_status;
                  gie_q   <= 1'b0;
                  state_q <= SQ_PUSH_PCL;
               end
            end
            SQ_PUSH_PCL: begin
               sp_q    <= sp_inc;
               state_q <= SQ_PUSH_PCH;
            end
            SQ_PUSH_PCH: begin
               sp_q    <= sp_inc;
               state_q <= SQ_PUSH_ST;
            end
            SQ_PUSH_ST: begin
               sp_q    <= sp_inc;
               state_q <= SQ_VEC_HI;
            end
            SQ_VEC_HI: begin
               hi_q    <= mem_rdata;
               state_q <= SQ_VEC_LO;
            end
            SQ_VEC_LO: begin
               pc_new_q  <= {hi_q, mem_rdata};
               pc_load_q <= 1'b1;
               isr_q     <= 1'b1;
               state_q   <= SQ_IDLE;
            end
            SQ_POP_ST: begin
               st_pop_q <= mem_rdata;
               sp_q     <= sp_dec;
               state_q  <= SQ_POP_PCH;
            end
            SQ_POP_PCH: begin
               hi_q    <= mem_rdata;
               sp_q    <= sp_dec;
               state_q <= SQ_POP_PCL;
            end
            SQ_POP_PCL: begin
               sp_q      <= sp_dec;
               pc_new_q  <= {hi_q, mem_rdata};
               pc_load_q <= 1'b1;
               st_new_q  <= st_pop_q;
               st_load_q <= 1'b1;
               gie_q     <= 1'b1;
               isr_q     <= 1'b0;
               state_q   <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign pc_load     = pc_load_q;
   assign pc_new      = pc_new_q;
   assign status_load = st_load_q;
   assign status_new  = st_new_q;
   assign irq_ack     = ack_q;
   assign busy        = ~idle;
   assign gie         = gie_q;
   assign isr_active  = isr_q;

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
   parameter int unsigned N = 2
) (
   input logic         clk,
   input logic         rst_n,
   input logic         insn_done,
   input logic         reti_req,
   input logic [N-1:0] src_en,
   input logic [N-1:0] irq_ack,
   input logic         gie,
   input logic         busy,
   input logic         pc_load,
   input logic         status_load,
   input logic         mem_we,
   input logic         mem_re,
   input logic         isr_active
);

   AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> $past(insn_done)); // R1
   AST_ACK_SRC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> ((irq_ack & ~$past(src_en)) == '0)); // R2
   AST_ACK_GIE_WAS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> $past(gie)); // R2
   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack)); // R3
   AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re)); // R4
   AST_STATUS_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
      status_load |-> pc_load); // R6
   AST_GIE_CLEARED_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> !gie); // R7
   AST_RETURN_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      status_load |-> gie); // R7
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |=> (irq_ack == '0)); // R8
   AST_BUSY_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> busy); // R9
   AST_LOAD_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> !busy); // R9
   AST_RETI_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_req && !isr_active && !busy && !insn_done) |=> !busy); // R9

endmodule

bind irq_vec_seq irq_seq_chk #(.N(NUM_SRC)) u_irq_seq_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .insn_done   (insn_done),
   .reti_req    (reti_req),
   .src_en      (src_en),
   .irq_ack     (irq_ack),
   .gie         (gie),
   .busy        (busy),
   .pc_load     (pc_load),
   .status_load (status_load),
   .mem_we      (mem_we),
   .mem_re      (mem_re),
   .isr_active  (isr_active)
);

// File: tb/test_irq_vec_seq.sv
module test_irq_vec_seq;

   localparam int unsigned NS   = 2;
   localparam logic [7:0]  SP0  = 8'h5F;
   localparam logic [2:0]  K_ACK = 3'd0, K_WR = 3'd1, K_RD = 3'd2, K_PC = 3'd3, K_ST = 3'd4;

   typedef struct packed {
      logic [2:0]  kind;
      logic [15:0] addr;
      logic [15:0] val;
   } ev_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] irq_req = '0;
   logic [NS-1:0] src_en = '0;
   logic          gie_wr = 1'b0;
   logic          gie_wr_val = 1'b0;
   logic          insn_done = 1'b0;
   logic [15:0]   cur_pc = '0;
   logic [7:0]    cur_status = '0;
   logic          reti_req = 1'b0;
   logic [15:0]   mem_addr;
   logic          mem_we, mem_re;
   logic [7:0]    mem_wdata, mem_rdata;
   logic          pc_load, status_load, busy, gie, isr_active;
   logic [15:0]   pc_new;
   logic [7:0]    status_new;
   logic [NS-1:0] irq_ack;

   logic [7:0] mem [0:1023];
   ev_t   exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   always #5 clk = ~clk;

   irq_vec_seq #(.NUM_SRC(NS), .SP_INIT(SP0)) i_irq_vec_seq (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .src_en(src_en),
      .gie_wr(gie_wr), .gie_wr_val(gie_wr_val), .insn_done(insn_done),
      .cur_pc(cur_pc), .cur_status(cur_status), .reti_req(reti_req),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .pc_load(pc_load), .pc_new(pc_new), .status_load(status_load),
      .status_new(status_new), .irq_ack(irq_ack), .busy(busy),
      .gie(gie), .isr_active(isr_active)
   );

   assign mem_rdata = mem[mem_addr[9:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic push_exp(input logic [2:0] k, input logic [15:0] a, input logic [15:0] v, input string tag);
      exp_q.push_back('{kind: k, addr: a, val: v});
      tag_q.push_back(tag);
   endtask

   // Monitor: every observed event is compared with the head of the scoreboard.
   task automatic observe(input logic [2:0] k, input logic [15:0] a, input logic [15:0] v);
      ev_t   e;
      string t;
      if (exp_q.size() == 0) begin
         chk(1'b0, "unexpected event (R1 R2 R8 R9)", int'({k, a, v}), 0);
      end else begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(e.kind == k && e.addr == a && e.val == v, t, int'({k, a, v}), int'({e.kind, e.addr, e.val}));
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (|irq_ack)   observe(K_ACK, 16'h0, 16'(irq_ack));
         if (mem_we)     observe(K_WR, mem_addr, 16'(mem_wdata));
         if (mem_re)     observe(K_RD, mem_addr, 16'h0);
         if (pc_load)    observe(K_PC, 16'h0, pc_new);
         if (status_load) observe(K_ST, 16'h0, 16'(status_new));
      end
   end

   // Driver-side expectation builders.
   task automatic exp_entry(input logic [1:0] mask, input logic [15:0] slot,
                            input logic [15:0] pc, input logic [7:0] st, input logic [15:0] hnd);
      push_exp(K_ACK, 16'h0, 16'(mask), "R3 ack source");
      push_exp(K_WR, 16'(SP0) + 16'd1, 16'(pc[7:0]),  "R4 push PC low");
      push_exp(K_WR, 16'(SP0) + 16'd2, 16'(pc[15:8]), "R4 push PC high");
      push_exp(K_WR, 16'(SP0) + 16'd3, 16'(st),       "R4 push status");
      push_exp(K_RD, slot,         16'h0, "R5 vector high read");
      push_exp(K_RD, slot + 16'd1, 16'h0, "R5 vector low read");
      push_exp(K_PC, 16'h0, hnd, "R5 handler PC");
   endtask

   task automatic exp_return(input logic [15:0] pc, input logic [7:0] st);
      push_exp(K_RD, 16'(SP0) + 16'd3, 16'h0, "R6 pop status");
      push_exp(K_RD, 16'(SP0) + 16'd2, 16'h0, "R6 pop PC high");
      push_exp(K_RD, 16'(SP0) + 16'd1, 16'h0, "R6 pop PC low");
      push_exp(K_PC, 16'h0, pc, "R6 resume PC");
      push_exp(K_ST, 16'h0, 16'(st), "R6 restored status");
   endtask

   task automatic pulse_req(input logic [1:0] m);
      @(posedge clk); #2 irq_req = m;
      @(posedge clk); #2 irq_req = '0;
   endtask

   task automatic boundary(input logic [15:0] pc, input logic [7:0] st);
      @(posedge clk); #2 cur_pc = pc; cur_status = st; insn_done = 1'b1;
      @(posedge clk); #2 insn_done = 1'b0;
   endtask

   task automatic do_reti();
      @(posedge clk); #2 reti_req = 1'b1;
      @(posedge clk); #2 reti_req = 1'b0;
   endtask

   task automatic write_gie(input logic v);
      @(posedge clk); #2 gie_wr = 1'b1; gie_wr_val = v;
      @(posedge clk); #2 gie_wr = 1'b0;
   endtask

   task automatic drain(input string tag);
      for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(posedge clk);
      repeat (4) @(posedge clk);
      chk(exp_q.size() == 0, tag, exp_q.size(), 0);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      mem[3] = 8'h12; mem[4] = 8'h34;
      mem[11] = 8'hAB; mem[12] = 8'hCD;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R9 busy after reset", busy, 0);
      chk(gie == 1'b0, "R10 gie after reset", gie, 0);
      chk(isr_active == 1'b0 && irq_ack == '0, "R1 idle after reset", irq_ack, 0);

      // Global enable off: request is held, nothing happens (R2, R10).
      src_en = 2'b11;
      pulse_req(2'b01);
      boundary(16'h4321, 8'hA5);
      drain("R2 no entry with gie low");
      chk(isr_active == 1'b0, "R2 gie low blocks entry", isr_active, 0);

      write_gie(1'b1);
      @(negedge clk);
      chk(gie == 1'b1, "R10 gie write", gie, 1);

      // Held request taken once enabled; busy on ack cycle (R2, R4, R5, R9).
      exp_entry(2'b01, 16'h0003, 16'h4321, 8'hA5, 16'h1234);
      boundary(16'h4321, 8'hA5);
      @(negedge clk);
      chk(busy == 1'b1, "R9 busy during entry", busy, 1);
      drain("R5 entry ext done");
      chk(isr_active == 1'b1, "R5 handler active", isr_active, 1);
      chk(gie == 1'b0, "R7 gie cleared on entry", gie, 0);
      chk(busy == 1'b0, "R9 busy released", busy, 0);

      // No nesting inside the handler (R7).
      pulse_req(2'b10);
      boundary(16'h9999, 8'h99);
      drain("R7 no nesting");

      exp_return(16'h4321, 8'hA5);
      do_reti();
      drain("R6 return ext");
      chk(gie == 1'b1, "R7 gie set on return", gie, 1);
      chk(isr_active == 1'b0, "R6 handler left", isr_active, 0);

      // Timer held from before is taken now (R2, R5 slot 000B).
      exp_entry(2'b10, 16'h000B, 16'h5000, 8'h3C, 16'hABCD);
      boundary(16'h5000, 8'h3C);
      drain("R5 entry timer");
      exp_return(16'h5000, 8'h3C);
      do_reti();
      drain("R6 return timer");

      // Priority: both pending, external first, timer next (R3).
      pulse_req(2'b11);
      exp_entry(2'b01, 16'h0003, 16'h6000, 8'h11, 16'h1234);
      boundary(16'h6000, 8'h11);
      drain("R3 ext wins");
      exp_return(16'h6000, 8'h11);
      do_reti();
      drain("R6 return after priority");
      exp_entry(2'b10, 16'h000B, 16'h6100, 8'h22, 16'hABCD);
      boundary(16'h6100, 8'h22);
      drain("R3 timer afterwards");
      exp_return(16'h6100, 8'h22);
      do_reti();
      drain("R6 return timer 2");

      // Per-source disable keeps it pending (R2).
      src_en = 2'b10;
      pulse_req(2'b01);
      boundary(16'h7000, 8'h77);
      drain("R2 disabled source not taken");
      chk(isr_active == 1'b0, "R2 disabled source", isr_active, 0);
      src_en = 2'b11;
      exp_entry(2'b01, 16'h0003, 16'h7000, 8'h77, 16'h1234);
      boundary(16'h7000, 8'h77);
      drain("R2 enabled later");
      exp_return(16'h7000, 8'h77);
      do_reti();
      drain("R6 return disabled case");

      // No boundary: no entry (R1).
      pulse_req(2'b10);
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk(isr_active == 1'b0 && busy == 1'b0, "R1 wait for boundary", busy, 0);
      exp_entry(2'b10, 16'h000B, 16'h8000, 8'h5A, 16'hABCD);
      boundary(16'h8000, 8'h5A);
      drain("R1 taken at boundary");
      exp_return(16'h8000, 8'h5A);
      do_reti();
      drain("R6 return boundary case");

      // Ack cleared the pending flag (R8).
      boundary(16'h8100, 8'h00);
      drain("R8 pending cleared by ack");
      chk(isr_active == 1'b0, "R8 no repeat entry", isr_active, 0);

      // Return request with no handler active is ignored (R9).
      do_reti();
      @(negedge clk);
      chk(busy == 1'b0, "R9 stray return ignored", busy, 0);
      drain("R9 no traffic on stray return");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog expired actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule